// File: doc/BRIEF.md
# Clear Channel Assessment Generator

This block decides whether the radio channel is busy or clear for a spread-spectrum receiver. When the receiver is switched on, it times fixed-length antenna dwells. At the close of each dwell it compares two measures with programmable thresholds. The first measure is a digitized received-signal-strength sample. The second is a correlator energy value integrated over a block of 15 symbols. The two results are held as an energy-detect flag and an early carrier-sense flag. The channel is reported busy while either flag is set.

From the moment the receiver is enabled until the first assessment, the output is forced busy, so that a controller never mistakes "not yet measured" for "clear". Before acquisition, the block alternates the antenna select at each dwell end, starting from a configured antenna. Once the receiver reports acquisition, the antenna stays put and the assessment period stretches to 64 symbols. Between assessments the output is held in a register, so a slower clock domain can sample it without glitches. A configuration bit picks the output polarity.

Top module: `cca_gen`

## Requirements
- R1: From the first cycle that `rxEnable` is high until the first assessment, `ccaOut` reports busy (high when `cfgActiveLow`=0).
- R2: The first assessment happens on the DWELL_US*CLKS_PER_US-th rising clock edge with `rxEnable` high. Later ones happen every DWELL_US*CLKS_PER_US edges while not acquired.
- R3: At an assessment, `edFlag` becomes 1 only if `rssiSample` is strictly greater than `cfgRssiThr`. Equality gives 0.
- R4: At an assessment, `cseFlag` becomes 1 only if `corrEnergy` is strictly greater than `cfgCseThr`. Equality gives 0.
- R5: The channel is busy when `edFlag` or `cseFlag` is 1, and clear only when both are 0.
- R6: With `cfgActiveLow`=1, `ccaOut` is low for busy and high for clear. With 0, it is high for busy.
- R7: Between assessments, changes of `rssiSample` and `corrEnergy` have no effect on `edFlag`, `cseFlag` or `ccaOut`.
- R8: On the rising edge of `acquired`, the dwell timer restarts. The next assessment comes ACQ_SYMBOLS*SYMBOL_US*CLKS_PER_US edges later, including the edge that sees `acquired` rise. While acquired, `antSel` does not change.
- R9: During the first dwell, `antSel` equals `cfgFirstAnt`. Before acquisition it inverts at every dwell-end assessment.
- R10: While `rxEnable` is low, both flags are 0, the output reports busy, the dwell timer is cleared and `antSel` follows `cfgFirstAnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enable; rising edge starts dwell timing |
| rssiSample | input | RSSI_W | Digitized signal strength sample |
| corrEnergy | input | ENERGY_W | Correlator energy integrated over 15 symbols |
| acquired | input | 1 | Receiver has acquired the signal |
| cfgRssiThr | input | RSSI_W | Signal-strength threshold register |
| cfgCseThr | input | ENERGY_W | Carrier-sense energy threshold register |
| cfgActiveLow | input | 1 | 1 selects active-low busy output |
| cfgFirstAnt | input | 1 | Antenna used for the first dwell |
| edFlag | output | 1 | Energy-detect flag |
| cseFlag | output | 1 | Early carrier-sense flag |
| ccaOut | output | 1 | Busy/clear indication, polarity per cfgActiveLow |
| antSel | output | 1 | Antenna select |

## Verification
The hardest situation to reach is the assessment after acquisition. It only occurs after a full pre-acquisition sequence of dwells, and it falls 128 edges after the acquisition edge rather than on the dwell grid. The stimulus first walks the receiver through several dwells with known antenna toggles. It then raises `acquired` in mid-sequence with the carrier-sense energy already above threshold. It samples one edge before and one edge after the expected assessment, so an off-by-one restart or a missed restart on the dwell grid shows as a wrong flag. Threshold-equal values and input changes in mid-dwell probe the strict compare and the hold.

// File: rtl/cca_pkg.sv
package cca_pkg;
  // Strobes from the dwell controller to the flag datapath.
  typedef struct packed {
    logic assess;  // dwell or post-acquisition period ends this cycle
    logic idle;    // receiver disabled: clear flags, force busy
  } ccaStrobe_t;
endpackage

// File: rtl/cca_ctrl.sv
module cca_ctrl
  import cca_pkg::*;
#(
  parameter int CLKS_PER_US = 2,
  parameter int DWELL_US    = 16,
  parameter int SYMBOL_US   = 1,
  parameter int ACQ_SYMBOLS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       acquired,
  input  logic       cfgFirstAnt,
  output ccaStrobe_t strobe,
  output logic       antSel
);
  localparam int DWELL_CLKS = CLKS_PER_US * DWELL_US;
  localparam int ACQ_CLKS   = CLKS_PER_US * SYMBOL_US * ACQ_SYMBOLS;
  localparam int MAX_CLKS   = (ACQ_CLKS > DWELL_CLKS) ? ACQ_CLKS : DWELL_CLKS;
  localparam int CNT_W      = $clog2(MAX_CLKS + 1);

  localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CLKS - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST   = CNT_W'(ACQ_CLKS - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] periodLast;
  logic             acqQ;
  logic             acqRise;
  logic             periodEnd;

  assign acqRise    = rxEnable & acquired & ~acqQ;
  assign periodLast = acquired ? ACQ_LAST : DWELL_LAST;
  // >= covers a period that shrinks when acquisition is lost mid-count
  assign periodEnd  = rxEnable & ~acqRise & (cycleCnt >= periodLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      acqQ     <= 1'b0;
      antSel   <= 1'b0;
    end else if (!rxEnable) begin
      cycleCnt <= '0;
      acqQ     <= 1'b0;
      antSel   <= cfgFirstAnt;
    end else begin
      acqQ <= acquired;
      if (acqRise)        cycleCnt <= CNT_W'(1);
      else if (periodEnd) cycleCnt <= '0;
      else                cycleCnt <= cycleCnt + 1'b1;
      if (periodEnd && !acquired) antSel <= ~antSel;
    end
  end

  always_comb begin
    strobe.assess = periodEnd;
    strobe.idle   = ~rxEnable;
  end
endmodule

// File: rtl/cca_dpath.sv
module cca_dpath
  import cca_pkg::*;
#(
  parameter int RSSI_W   = 8,
  parameter int ENERGY_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ccaStrobe_t          strobe,
  input  logic [RSSI_W-1:0]   rssiSample,
  input  logic [RSSI_W-1:0]   cfgRssiThr,
  input  logic [ENERGY_W-1:0] corrEnergy,
  input  logic [ENERGY_W-1:0] cfgCseThr,
  input  logic                cfgActiveLow,
  output logic                edFlag,
  output logic                cseFlag,
  output logic                ccaOut
);
  logic edHit;
  logic cseHit;
  logic busyQ;

  assign edHit  = rssiSample > cfgRssiThr;
  assign cseHit = corrEnergy > cfgCseThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edFlag  <= 1'b0;
      cseFlag <= 1'b0;
      busyQ   <= 1'b1;
    end else if (strobe.idle) begin
      edFlag  <= 1'b0;
      cseFlag <= 1'b0;
      busyQ   <= 1'b1;
    end else if (strobe.assess) begin
      edFlag  <= edHit;
      cseFlag <= cseHit;
      busyQ   <= edHit | cseHit;
    end
  end

  // polarity is a static setting; the output is a register through an xor
  assign ccaOut = busyQ ^ cfgActiveLow;
endmodule

// File: rtl/cca_gen.sv
module cca_gen
  import cca_pkg::*;
#(
  parameter int CLKS_PER_US = 2,
  parameter int DWELL_US    = 16,
  parameter int SYMBOL_US   = 1,
  parameter int ACQ_SYMBOLS = 64,
  parameter int RSSI_W      = 8,
  parameter int ENERGY_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxEnable,
  input  logic [RSSI_W-1:0]   rssiSample,
  input  logic [ENERGY_W-1:0] corrEnergy,
  input  logic                acquired,
  input  logic [RSSI_W-1:0]   cfgRssiThr,
  input  logic [ENERGY_W-1:0] cfgCseThr,
  input  logic                cfgActiveLow,
  input  logic                cfgFirstAnt,
  output logic                edFlag,
  output logic                cseFlag,
  output logic                ccaOut,
  output logic                antSel
);
  ccaStrobe_t ctrlStrobe;

  cca_ctrl #(
    .CLKS_PER_US(CLKS_PER_US),
    .DWELL_US   (DWELL_US),
    .SYMBOL_US  (SYMBOL_US),
    .ACQ_SYMBOLS(ACQ_SYMBOLS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .acquired   (acquired),
    .cfgFirstAnt(cfgFirstAnt),
    .strobe     (ctrlStrobe),
    .antSel     (antSel)
  );

  cca_dpath #(
    .RSSI_W  (RSSI_W),
    .ENERGY_W(ENERGY_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (ctrlStrobe),
    .rssiSample  (rssiSample),
    .cfgRssiThr  (cfgRssiThr),
    .corrEnergy  (corrEnergy),
    .cfgCseThr   (cfgCseThr),
    .cfgActiveLow(cfgActiveLow),
    .edFlag      (edFlag),
    .cseFlag     (cseFlag),
    .ccaOut      (ccaOut)
  );
endmodule

// File: rtl/cca_gen_chk.sv
module cca_gen_chk #(
  parameter int RSSI_W   = 8,
  parameter int ENERGY_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                rxEnable,
  input logic [RSSI_W-1:0]   rssiSample,
  input logic [ENERGY_W-1:0] corrEnergy,
  input logic                acquired,
  input logic [RSSI_W-1:0]   cfgRssiThr,
  input logic [ENERGY_W-1:0] cfgCseThr,
  input logic                cfgActiveLow,
  input logic                cfgFirstAnt,
  input logic                edFlag,
  input logic                cseFlag,
  input logic                ccaOut,
  input logic                antSel,
  input logic                strobeAssess
);
  assert_busy_on_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> (ccaOut != cfgActiveLow));

  assert_ed_compare_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobeAssess |=> (edFlag == ($past(rssiSample) > $past(cfgRssiThr))));

  assert_cse_compare_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobeAssess |=> (cseFlag == ($past(corrEnergy) > $past(cfgCseThr))));

  assert_flag_means_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (edFlag || cseFlag) |-> (ccaOut != cfgActiveLow));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && $past(rxEnable) && !$past(strobeAssess) && $stable(cfgActiveLow))
      |-> ($stable(edFlag) && $stable(cseFlag) && $stable(ccaOut)));

  assert_ant_fixed_acq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && acquired) |=> $stable(antSel));

  assert_ant_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (antSel == $past(cfgFirstAnt)));

  assert_idle_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!edFlag && !cseFlag && (ccaOut != cfgActiveLow)));
endmodule

bind cca_gen cca_gen_chk #(.RSSI_W(RSSI_W), .ENERGY_W(ENERGY_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxEnable    (rxEnable),
  .rssiSample  (rssiSample),
  .corrEnergy  (corrEnergy),
  .acquired    (acquired),
  .cfgRssiThr  (cfgRssiThr),
  .cfgCseThr   (cfgCseThr),
  .cfgActiveLow(cfgActiveLow),
  .cfgFirstAnt (cfgFirstAnt),
  .edFlag      (edFlag),
  .cseFlag     (cseFlag),
  .ccaOut      (ccaOut),
  .antSel      (antSel),
  .strobeAssess(ctrlStrobe.assess)
);

// File: tb/test_cca_gen.sv
module test_cca_gen;
  localparam int CLKS_PER_US = 2;
  localparam int DWELL_US    = 16;
  localparam int SYMBOL_US   = 1;
  localparam int ACQ_SYMBOLS = 64;
  localparam int RSSI_W      = 8;
  localparam int ENERGY_W    = 16;
  localparam int DWELL_CLKS  = CLKS_PER_US * DWELL_US;
  localparam int ACQ_CLKS    = CLKS_PER_US * SYMBOL_US * ACQ_SYMBOLS;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                rxEnable = 1'b0;
  logic [RSSI_W-1:0]   rssiSample = '0;
  logic [ENERGY_W-1:0] corrEnergy = '0;
  logic                acquired = 1'b0;
  logic [RSSI_W-1:0]   cfgRssiThr = 8'd50;
  logic [ENERGY_W-1:0] cfgCseThr = 16'd500;
  logic                cfgActiveLow = 1'b0;
  logic                cfgFirstAnt = 1'b1;
  logic                edFlag, cseFlag, ccaOut, antSel;

  always #4 clk = ~clk;

  cca_gen #(
    .CLKS_PER_US(CLKS_PER_US), .DWELL_US(DWELL_US), .SYMBOL_US(SYMBOL_US),
    .ACQ_SYMBOLS(ACQ_SYMBOLS), .RSSI_W(RSSI_W), .ENERGY_W(ENERGY_W)
  ) i_cca_gen (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rssiSample(rssiSample),
    .corrEnergy(corrEnergy), .acquired(acquired), .cfgRssiThr(cfgRssiThr),
    .cfgCseThr(cfgCseThr), .cfgActiveLow(cfgActiveLow), .cfgFirstAnt(cfgFirstAnt),
    .edFlag(edFlag), .cseFlag(cseFlag), .ccaOut(ccaOut), .antSel(antSel)
  );

  typedef struct {
    logic  cca;
    logic  ed;
    logic  cse;
    logic  ant;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;
  int       checks = 0;
  int       fails = 0;
  bit       done = 0;

  // Driver side: advance n rising edges, then at the falling edge queue the expectation.
  task automatic expectAfter(input int n, input logic c, input logic e,
                             input logic s, input logic a, input string tag);
    expItem_t it;
    repeat (n) @(posedge clk);
    @(negedge clk);
    it.cca = c; it.ed = e; it.cse = s; it.ant = a; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  // Monitor side: pop and compare against the ports.
  initial begin
    forever begin
      expItem_t it;
      @(sampleEv);
      while (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (ccaOut !== it.cca || edFlag !== it.ed || cseFlag !== it.cse || antSel !== it.ant) begin
          fails++;
          $display("FAIL %s: actual cca=%b ed=%b cse=%b ant=%b expected cca=%b ed=%b cse=%b ant=%b",
                   it.tag, ccaOut, edFlag, cseFlag, antSel, it.cca, it.ed, it.cse, it.ant);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: busy, no flags (R10)
    expectAfter(1, 1, 0, 0, 1, "R10 reset/idle state");

    // first dwell, quiet channel
    rssiSample = 8'd10; corrEnergy = 16'd100; rxEnable = 1'b1;
    expectAfter(DWELL_CLKS - 1, 1, 0, 0, 1, "R1 forced busy before first assessment");
    expectAfter(1, 0, 0, 0, 0, "R2 first assessment clear, R9 antenna toggles");

    // strong RSSI arrives, but the output holds until dwell end
    rssiSample = 8'd80;
    expectAfter(DWELL_CLKS - 1, 0, 0, 0, 0, "R7 output held mid-dwell");
    expectAfter(1, 1, 1, 0, 1, "R3 rssi above threshold, R5 busy");

    // RSSI equal threshold, energy above
    rssiSample = 8'd50; corrEnergy = 16'd600;
    expectAfter(DWELL_CLKS, 1, 0, 1, 0, "R3 equal gives no ed, R4 cse above threshold");

    // both equal threshold, active-low polarity
    rssiSample = 8'd10; corrEnergy = 16'd500; cfgActiveLow = 1'b1;
    expectAfter(0, 0, 0, 1, 0, "R6 busy shown low in active-low mode");
    expectAfter(DWELL_CLKS, 1, 0, 0, 1, "R4 equal gives no cse, R6 clear shown high");
    cfgActiveLow = 1'b0;

    // mid-dwell input changes ignored
    expectAfter(10, 0, 0, 0, 1, "R7 hold after polarity restore");
    corrEnergy = 16'd900;
    expectAfter(5, 0, 0, 0, 1, "R7 energy change ignored mid-dwell");

    // acquisition restarts the timer with the longer period
    acquired = 1'b1;
    expectAfter(DWELL_CLKS + 4, 0, 0, 0, 1, "R8 no assessment on dwell grid after acquisition");
    expectAfter(ACQ_CLKS - DWELL_CLKS - 5, 0, 0, 0, 1, "R8 still held one edge before period end");
    expectAfter(1, 1, 0, 1, 1, "R8 assessment after 64 symbols, antenna kept");
    corrEnergy = 16'd100;
    expectAfter(ACQ_CLKS, 0, 0, 0, 1, "R8 carrier sense drops on loss, R5 clear");

    // disable receiver
    rxEnable = 1'b0; acquired = 1'b0; cfgFirstAnt = 1'b0; rssiSample = 8'd200;
    expectAfter(1, 1, 0, 0, 0, "R10 disable clears flags, forces busy, loads antenna");

    // re-enable, starting antenna 0
    rssiSample = 8'd10; rxEnable = 1'b1;
    expectAfter(DWELL_CLKS - 1, 1, 0, 0, 0, "R1 forced busy again, R9 first antenna");
    expectAfter(1, 0, 0, 0, 1, "R2 assessment after re-enable, R9 toggle");

    done = 1;
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule